// File: doc/BRIEF.md
# PIR Motion Pulse Recognition Controller

This block is the digital back end of a passive-infrared motion detector. It runs from a slow system clock (nominally 62.5 Hz) and watches two window-comparator outputs: one fires when the amplified sensor signal rises above an upper threshold, the other when it falls below a lower one. Both comparator lines are asynchronous. Each passes through a two-flop synchronizer and then a deglitch filter that counts consecutive high samples. A run of three or more high samples produces one accepted pulse event.

After reset, a start-up phase blanks the motion output for 1875 cycles (about 30 s) and blinks the LED at roughly 2 Hz. Once the start-up phase ends, accepted pulses go to a recognizer with two modes. In single mode any accepted pulse is motion. In dual mode, motion needs accepted pulses from both comparators, and the second must arrive within 312 cycles (about 5 s) of the first. A motion detection raises the motion output for 100 cycles (about 1.6 s). The LED copies the motion output when the active-low LED enable is low.

Top module: `pir_motion_ctrl`

## Requirements
- R1: For STARTUP_CYC (1875) cycles after reset is released, motion_o stays low whatever the comparator inputs do.
- R2: During start-up, led_o toggles every LED_HALF (16) cycles whatever led_en_n_i is, and stops blinking when start-up ends.
- R3: A comparator high run that lasts at most two clock cycles is never accepted and never produces motion.
- R4: A comparator high run of three or more clock cycles is accepted exactly once, however long it lasts.
- R5: With mode_dual_i = 0, one accepted pulse from either comparator raises motion_o within 8 cycles of the rising edge of the input.
- R6: With mode_dual_i = 1, accepted pulses from opposite comparators no more than DUAL_WIN (312) cycles apart raise motion_o. A lone pulse does not.
- R7: With mode_dual_i = 1, if no opposite pulse arrives within DUAL_WIN cycles of the first, recognition returns to idle and the late pulse counts only as a new first pulse.
- R8: Each detection holds motion_o high for exactly HOLD_CYC (100) consecutive cycles.
- R9: After start-up, led_o equals motion_o when led_en_n_i = 0 and is held low when led_en_n_i = 1.
- R10: With mode_dual_i = 1, a second pulse from the same comparator inside the window restarts the window from that pulse.
- R11: Comparator pulses that arrive while motion_o is high neither extend nor retrigger the output. Recognition restarts from idle once the output falls.
- R12: While reset is asserted and right after it, motion_o and led_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_hi_i | input | 1 | Upper-threshold comparator, asynchronous |
| comp_lo_i | input | 1 | Lower-threshold comparator, asynchronous |
| mode_dual_i | input | 1 | 0 = single-pulse recognition, 1 = dual-pulse recognition |
| led_en_n_i | input | 1 | Active-low LED enable after start-up |
| motion_o | output | 1 | Motion detected output, high for HOLD_CYC cycles |
| led_o | output | 1 | LED drive |

## Verification
The assertions assume that the mode input stays constant while a dual-pulse window is open, and that the comparator lines settle between clock edges once they have passed the synchronizer. The stimulus changes every input only on the falling clock edge. It changes the mode only while the recognizer is idle. It leaves at least two low cycles between consecutive random glitches, so that short runs cannot merge into one accepted run. The random pulse widths are drawn on both sides of the acceptance threshold, and each draw is compared with a bench function that predicts acceptance from the width alone.

// File: rtl/pir_motion_pkg.sv
// Shared types for the PIR motion controller.
package pir_motion_pkg;

    // Recognizer state
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_WAIT = 2'd1,
        RS_HOLD = 2'd2
    } recog_state_e;

    // Which comparator produced the first pulse of a dual-pulse pair
    typedef enum logic {
        SRC_HI = 1'b0,
        SRC_LO = 1'b1
    } pulse_src_e;

endpackage

// File: rtl/pir_deglitch.sv
// Synchronizes one asynchronous comparator line and filters out short runs.
// Assumes: the input may change at any time; a run of ACCEPT_RUN consecutive
// high synchronized samples yields exactly one single-cycle event.
module pir_deglitch #(
    parameter int ACCEPT_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_i,
    output logic event_o
);
    localparam int CW = $clog2(ACCEPT_RUN + 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] run_q;

    // Two-flop synchronizer for the asynchronous comparator line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= comp_i;
            sync_q <= meta_q;
        end
    end

    // Count consecutive high samples, saturating at the acceptance length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sync_q) begin
            run_q <= '0;
        end else if (run_q != CW'(ACCEPT_RUN)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // One event on the sample that completes the required run
    assign event_o = sync_q && (run_q == CW'(ACCEPT_RUN - 1));

    AST_ONE_EVENT_PER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o); // R4

    AST_EVENT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> $past(meta_q)); // R3

endmodule

// File: rtl/pir_startup.sv
// Start-up sequencer: blanks recognition for STARTUP_CYC cycles after reset
// and produces a blink signal that toggles every LED_HALF cycles meanwhile.
// Assumes: the count starts in the first cycle after reset is released.
module pir_startup #(
    parameter int STARTUP_CYC = 1875,
    parameter int LED_HALF    = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic blank_o,
    output logic blink_o
);
    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam int BW = $clog2(LED_HALF + 1);

    logic [SW-1:0] su_cnt_q;
    logic [BW-1:0] half_cnt_q;
    logic          blink_q;

    // Start-up duration counter, stops at its limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            su_cnt_q <= '0;
        end else if (su_cnt_q != SW'(STARTUP_CYC)) begin
            su_cnt_q <= su_cnt_q + 1'b1;
        end
    end

    assign blank_o = (su_cnt_q != SW'(STARTUP_CYC));

    // Blink divider, active only while blanking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt_q <= '0;
            blink_q    <= 1'b0;
        end else if (blank_o) begin
            if (half_cnt_q == BW'(LED_HALF - 1)) begin
                half_cnt_q <= '0;
                blink_q    <= ~blink_q;
            end else begin
                half_cnt_q <= half_cnt_q + 1'b1;
            end
        end
    end

    assign blink_o = blink_q;

    AST_BLINK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_o |=> $stable(blink_q)); // R2

    AST_BLANK_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_o |=> !blank_o); // R1

endmodule

// File: rtl/pir_recog.sv
// Pulse recognizer: single or dual-pulse motion detection with a timeout
// window and a fixed-length output pulse. Events arriving during blanking
// or while the output is high are ignored.
// Assumes: events are single-cycle; the mode is steady while a window is open.
module pir_recog
    import pir_motion_pkg::*;
#(
    parameter int DUAL_WIN = 312,
    parameter int HOLD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blank_i,
    input  logic mode_dual_i,
    input  logic ev_hi_i,
    input  logic ev_lo_i,
    output logic motion_o
);
    localparam int WW = $clog2(DUAL_WIN + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);

    recog_state_e  state_q;
    pulse_src_e    first_q;
    logic [WW-1:0] win_q;
    logic [HW-1:0] hold_q;
    logic          ev_same;
    logic          ev_opp;

    // Classify incoming events against the stored first pulse
    always_comb begin
        ev_same = (first_q == SRC_HI) ? ev_hi_i : ev_lo_i;
        ev_opp  = (first_q == SRC_HI) ? ev_lo_i : ev_hi_i;
    end

    // Recognition state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            first_q <= SRC_HI;
            win_q   <= '0;
            hold_q  <= '0;
        end else begin
            case (state_q)
                RS_IDLE: begin
                    if (!blank_i) begin
                        if (!mode_dual_i || (ev_hi_i && ev_lo_i)) begin
                            if (ev_hi_i || ev_lo_i) begin
                                state_q <= RS_HOLD;
                                hold_q  <= HW'(HOLD_CYC - 1);
                            end
                        end else if (ev_hi_i || ev_lo_i) begin
                            state_q <= RS_WAIT;
                            first_q <= ev_hi_i ? SRC_HI : SRC_LO;
                            win_q   <= '0;
                        end
                    end
                end
                RS_WAIT: begin
                    if (ev_opp) begin
                        state_q <= RS_HOLD;
                        hold_q  <= HW'(HOLD_CYC - 1);
                    end else if (ev_same) begin
                        win_q <= '0;
                    end else if (win_q == WW'(DUAL_WIN - 1)) begin
                        state_q <= RS_IDLE;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                RS_HOLD: begin
                    if (hold_q == '0) begin
                        state_q <= RS_IDLE;
                    end else begin
                        hold_q <= hold_q - 1'b1;
                    end
                end
                default: state_q <= RS_IDLE;
            endcase
        end
    end

    assign motion_o = (state_q == RS_HOLD);

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_WAIT) |-> (win_q < WW'(DUAL_WIN))); // R7

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HOLD && $past(state_q) == RS_HOLD && $past(rst_n))
        |-> (hold_q == $past(hold_q) - 1'b1)); // R11

    AST_HOLD_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HOLD && hold_q != '0) |=> (state_q == RS_HOLD)); // R8

    AST_NO_WAIT_IN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && !mode_dual_i) |=> (state_q != RS_WAIT)); // R5

endmodule

// File: rtl/pir_motion_ctrl.sv
// Top of the PIR motion controller: two deglitch channels, the start-up
// sequencer, the recognizer and LED output selection.
// Assumes: clk is the slow system oscillator; rst_n is synchronous.
module pir_motion_ctrl #(
    parameter int STARTUP_CYC = 1875,
    parameter int LED_HALF    = 16,
    parameter int ACCEPT_RUN  = 3,
    parameter int DUAL_WIN    = 312,
    parameter int HOLD_CYC    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_hi_i,
    input  logic comp_lo_i,
    input  logic mode_dual_i,
    input  logic led_en_n_i,
    output logic motion_o,
    output logic led_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] comp_raw;
    logic [NCH-1:0] comp_ev;
    logic           blank;
    logic           blink;
    logic           motion;

    assign comp_raw = {comp_lo_i, comp_hi_i};

    // One deglitch channel per comparator
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pir_deglitch #(
            .ACCEPT_RUN(ACCEPT_RUN)
        ) u_dg (
            .clk    (clk),
            .rst_n  (rst_n),
            .comp_i (comp_raw[g]),
            .event_o(comp_ev[g])
        );
    end

    pir_startup #(
        .STARTUP_CYC(STARTUP_CYC),
        .LED_HALF   (LED_HALF)
    ) u_su (
        .clk    (clk),
        .rst_n  (rst_n),
        .blank_o(blank),
        .blink_o(blink)
    );

    pir_recog #(
        .DUAL_WIN(DUAL_WIN),
        .HOLD_CYC(HOLD_CYC)
    ) u_rc (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank_i    (blank),
        .mode_dual_i(mode_dual_i),
        .ev_hi_i    (comp_ev[0]),
        .ev_lo_i    (comp_ev[1]),
        .motion_o   (motion)
    );

    // Output selection: blink during start-up, gated motion afterwards
    always_comb begin
        motion_o = motion;
        led_o    = blank ? blink : (motion && !led_en_n_i);
    end

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !motion_o); // R1

    AST_LED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && led_en_n_i) |-> !led_o); // R9

    AST_LED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && !led_en_n_i) |-> (led_o == motion_o)); // R9

endmodule

// File: tb/pir_motion_ctrl_tb.sv
module pir_motion_ctrl_tb_top;
    localparam int STARTUP_CYC = 1875;
    localparam int LED_HALF    = 16;
    localparam int DUAL_WIN    = 312;
    localparam int HOLD_CYC    = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comp_hi = 1'b0;
    logic comp_lo = 1'b0;
    logic mode_dual = 1'b0;
    logic led_en_n = 1'b1;
    logic motion;
    logic led;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pir_motion_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .comp_hi_i  (comp_hi),
        .comp_lo_i  (comp_lo),
        .mode_dual_i(mode_dual),
        .led_en_n_i (led_en_n),
        .motion_o   (motion),
        .led_o      (led)
    );

    // Acceptance predicted from the run width alone
    function automatic bit exp_accept(input int width);
        return width >= 3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one high run on a comparator (0 = upper, 1 = lower)
    task automatic pulse(input bit which, input int width);
        if (which) comp_lo = 1'b1; else comp_hi = 1'b1;
        cyc(width);
        comp_lo = 1'b0;
        comp_hi = 1'b0;
    endtask

    // Watch for motion to rise within a number of cycles
    task automatic saw_motion(input int span, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < span; i++) begin
            cyc(1);
            if (motion) seen = 1'b1;
        end
    endtask

    // Wait for a rise, then count the high cycles
    task automatic measure_hold(output int len);
        int t;
        len = 0;
        t = 0;
        while (!motion && t < 40) begin cyc(1); t++; end
        while (motion && len < 400) begin cyc(1); len++; end
    endtask

    task automatic drain();
        while (motion) cyc(1);
        cyc(DUAL_WIN + 20);
    endtask

    initial begin
        #(64'd200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit seen;
        int len;
        int toggles;
        bit motion_seen;
        bit last_led;
        void'($urandom(32'd4242));

        cyc(5);
        check(!motion && !led, "R12 reset outputs", {motion, led}, 0);
        rst_n = 1'b1;

        // Start-up: blanking with comparator activity, and blink counting
        toggles = 0;
        motion_seen = 1'b0;
        last_led = led;
        for (int i = 0; i < STARTUP_CYC - 5; i++) begin
            if (i == 200 || i == 900) comp_hi = 1'b1;
            if (i == 210 || i == 910) comp_hi = 1'b0;
            if (i == 500) comp_lo = 1'b1;
            if (i == 520) comp_lo = 1'b0;
            if (i == 1000) led_en_n = 1'b0;
            cyc(1);
            if (motion) motion_seen = 1'b1;
            if (led != last_led) toggles++;
            last_led = led;
        end
        check(!motion_seen, "R1 motion during start-up", motion_seen, 0);
        check(toggles >= (STARTUP_CYC / LED_HALF) - 6 && toggles <= (STARTUP_CYC / LED_HALF) + 1,
              "R2 blink toggles", toggles, STARTUP_CYC / LED_HALF);

        // After start-up: LED disabled, steady
        led_en_n = 1'b1;
        cyc(40);
        toggles = 0;
        last_led = led;
        for (int i = 0; i < 60; i++) begin
            cyc(1);
            if (led != last_led) toggles++;
            last_led = led;
        end
        check(toggles == 0 && !led, "R2 blink stops", toggles, 0);

        // Single mode, upper comparator, LED enabled
        mode_dual = 1'b0;
        led_en_n = 1'b0;
        pulse(1'b0, 4);
        saw_motion(6, seen);
        check(seen, "R5 single upper", seen, 1);
        check(led == motion, "R9 led follows motion", led, motion);
        drain();

        // Single mode, lower comparator, LED disabled, hold length
        led_en_n = 1'b1;
        fork
            measure_hold(len);
            pulse(1'b1, 5);
        join
        check(len == HOLD_CYC, "R8 hold length", len, HOLD_CYC);
        drain();

        // Long run accepted only once
        fork
            measure_hold(len);
            pulse(1'b0, 150);
        join
        check(len == HOLD_CYC, "R4 long run one event", len, HOLD_CYC);
        cyc(30);
        check(!motion, "R4 no second event", motion, 0);
        drain();

        // Pulse during hold ignored
        fork
            measure_hold(len);
            begin pulse(1'b0, 4); cyc(30); pulse(1'b1, 6); end
        join
        check(len == HOLD_CYC, "R11 hold not extended", len, HOLD_CYC);
        saw_motion(30, seen);
        check(!seen, "R11 no retrigger", seen, 0);
        drain();

        // Random widths around the threshold, single mode
        for (int k = 0; k < 30; k++) begin
            int w;
            bit which;
            w = 1 + int'($urandom_range(0, 5));
            which = 1'($urandom_range(0, 1));
            pulse(which, w);
            saw_motion(10, seen);
            check(seen == exp_accept(w), exp_accept(w) ? "R4 random accept" : "R3 random reject",
                  seen, exp_accept(w));
            drain();
        end

        // Burst of short glitches separated by low gaps
        for (int k = 0; k < 20; k++) begin
            pulse(1'($urandom_range(0, 1)), 1 + int'($urandom_range(0, 1)));
            cyc(2 + int'($urandom_range(0, 3)));
        end
        saw_motion(10, seen);
        check(!seen, "R3 glitch burst", seen, 0);

        // Dual mode
        mode_dual = 1'b1;
        pulse(1'b0, 5);
        saw_motion(DUAL_WIN + 20, seen);
        check(!seen, "R6 lone pulse", seen, 0);
        drain();

        pulse(1'b0, 5);
        cyc(100 - 5);
        pulse(1'b1, 5);
        saw_motion(10, seen);
        check(seen, "R6 opposite within window", seen, 1);
        drain();

        pulse(1'b1, 5);
        cyc(400 - 5);
        pulse(1'b0, 5);
        saw_motion(10, seen);
        check(!seen, "R7 window expired", seen, 0);
        cyc(100 - 15);
        pulse(1'b1, 5);
        saw_motion(10, seen);
        check(seen, "R7 late pulse is new first", seen, 1);
        drain();

        pulse(1'b0, 5);
        cyc(250 - 5);
        pulse(1'b0, 5);
        cyc(250 - 5);
        pulse(1'b1, 5);
        saw_motion(10, seen);
        check(seen, "R10 same-side restart", seen, 1);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule